// File: doc/BRIEF.md
# External Memory Bus Sequencer

This block takes one memory request at a time from a processor core and runs it as a cycle on an asynchronous external bus. That bus is split into four banks. Each request carries an address, a direction, an operand width, a write word and a qualifier that says whether the instruction's condition held. The block decodes the bank from the address and drives active-low bank selects, active-low read and write strobes and an early write warning. It places the operand on the correct byte lanes of a 48-bit data bus. When a bank 0 access moves into a new DRAM page, it flags that with a page-change output. The strobe phase lasts at least a programmed number of wait states, and it is stretched for as long as the external acknowledge is low. The block then returns a completion with right-justified read data.

Requests enter through a valid/ready pair. `req_ready` is high only while the sequencer is idle, so the core may hold `req_valid` with stable fields for as long as it likes. A completion is offered on `rsp_valid` with `rsp_rdata`. It stays offered, with the data unchanged, until the core raises `rsp_ready`. A new request is accepted only after that handshake. Bank size and page size are set as powers of two through plain configuration inputs. The minimum wait count is also a plain configuration input.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While an access is on the bus, `mem_sel_n[b]` is low for exactly one bank b when `addr >> cfg_bank_shift` equals b (b < 4). All selects stay high when that value is 4 or more. The selects and `mem_addr` take their access values in the first cycle after acceptance (the address cycle).
- R2: All four selects are high whenever no access is on the bus: while idle, and in the completion cycle.
- R3: An access whose `req_cond` is 0 still drives its address and bank select for one address cycle. It then completes with no read or write strobe. A false-condition read returns 0.
- R4: For a write, `mem_wr_early_n` is low from the address cycle until the strobe ends. A false-condition write holds it low for the address cycle only, and `mem_wr_n` never falls.
- R5: A true-condition access drives its strobe low (`mem_rd_n` for reads, `mem_wr_n` for writes) for `max(cfg_min_wait, A) + 1` consecutive cycles. Here A is the number of strobe cycles, counted from the first, that end with `mem_ack` low.
- R6: While a strobe is low and `mem_ack` is sampled low at a rising edge, the strobe is still low in the next cycle.
- R7: `mem_page_cross` is high during an access only if that access is in bank 0. Its page number is `addr >> cfg_page_shift`. It is high when that page differs from the page of the previous bank 0 access, or when there has been no bank 0 access since reset.
- R8: During a write strobe, `mem_doe` is high and `mem_dout` carries the operand in lanes chosen by `req_width`: 0 = 32 bits on [47:16], 1 = 40 bits on [47:8], 2 = 16 bits on [31:16], 3 = 8 bits on [23:16]. All other bits are zero.
- R9: A completed true-condition read returns the `mem_din` lanes selected by R8's width code, zero-extended and right-justified, as sampled at the final strobe edge. A write returns 0.
- R10: `req_ready` is high only when idle. `rsp_valid` and `rsp_rdata` hold unchanged while `rsp_ready` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_bank_shift | input | SH_W | log2 of bank size in address units |
| cfg_page_shift | input | SH_W | log2 of DRAM page size in address units |
| cfg_min_wait | input | WAIT_W | Minimum wait states before acknowledge counts |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Request accepted (idle) |
| req_addr | input | ADDR_W | Request address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_width | input | 2 | Operand width code (see R8) |
| req_wdata | input | 40 | Write operand, right-justified |
| req_cond | input | 1 | Condition true qualifier |
| rsp_valid | output | 1 | Completion offered |
| rsp_ready | input | 1 | Completion taken |
| rsp_rdata | output | 40 | Read operand, right-justified |
| mem_addr | output | ADDR_W | Bus address |
| mem_sel_n | output | 4 | Bank selects, active low |
| mem_rd_n | output | 1 | Read strobe, active low |
| mem_wr_n | output | 1 | Write strobe, active low |
| mem_wr_early_n | output | 1 | Early write indication, active low |
| mem_page_cross | output | 1 | Bank 0 page change |
| mem_dout | output | 48 | Bus write data |
| mem_doe | output | 1 | Bus write data valid |
| mem_din | input | 48 | Bus read data |
| mem_ack | input | 1 | Acknowledge; low adds wait states |

## Verification
The minimum wait count and the acknowledge input decide together when a strobe ends. The bench therefore sweeps every pairing of minimum wait 0 to 2 with acknowledge held low for 0 to 2 strobe cycles. Each pairing is crossed with every width code, both directions and both condition values, so the cases where the wait count expires on the same edge as acknowledge rises all occur. The bench counts the strobe-low cycles and compares the count with the larger of the two limits plus one. In the same access it also checks the lane placement and the read data captured on that edge.

// File: rtl/ebc_pkg.sv
package ebc_pkg;
  localparam int BUS_W  = 48;
  localparam int CORE_W = 40;
  localparam int NBANK  = 4;

  typedef enum logic [1:0] {
    OP_W32 = 2'd0,
    OP_W40 = 2'd1,
    OP_W16 = 2'd2,
    OP_W8  = 2'd3
  } op_width_t;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_STRB,
    ST_WAIT,
    ST_DONE
  } seq_state_t;
endpackage

// File: rtl/ebc_bank_decode.sv
module ebc_bank_decode #(
  parameter int ADDR_W = 32,
  parameter int NBANK  = 4,
  parameter int SH_W   = $clog2(ADDR_W)
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [SH_W-1:0]   bank_shift,
  input  logic [SH_W-1:0]   page_shift,
  output logic [NBANK-1:0]  sel_oh,
  output logic [ADDR_W-1:0] page_no
);
  logic [ADDR_W-1:0] hi;

  always_comb begin
    hi      = addr >> bank_shift;
    page_no = addr >> page_shift;
  end

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign sel_oh[b] = (hi == ADDR_W'(b));
  end
endmodule

// File: rtl/ebc_lane_mux.sv
module ebc_lane_mux
  import ebc_pkg::*;
(
  input  op_width_t          width,
  input  logic [CORE_W-1:0]  core_wdata,
  output logic [BUS_W-1:0]   bus_wdata,
  input  logic [BUS_W-1:0]   bus_rdata,
  output logic [CORE_W-1:0]  core_rdata
);
  always_comb begin
    bus_wdata  = '0;
    core_rdata = '0;
    unique case (width)
      OP_W32: begin
        bus_wdata[47:16] = core_wdata[31:0];
        core_rdata[31:0] = bus_rdata[47:16];
      end
      OP_W40: begin
        bus_wdata[47:8]  = core_wdata[39:0];
        core_rdata[39:0] = bus_rdata[47:8];
      end
      OP_W16: begin
        bus_wdata[31:16] = core_wdata[15:0];
        core_rdata[15:0] = bus_rdata[31:16];
      end
      OP_W8: begin
        bus_wdata[23:16] = core_wdata[7:0];
        core_rdata[7:0]  = bus_rdata[23:16];
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
  import ebc_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              cond,
  input  logic [WAIT_W-1:0] min_wait,
  input  logic              ack,
  input  logic              rsp_ready,
  output seq_state_t        state,
  output logic              finish
);
  logic [WAIT_W-1:0] wcnt;

  always_comb
    finish = (state == ST_STRB || state == ST_WAIT) && (wcnt >= min_wait) && ack;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      wcnt  <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          state <= ST_ADDR;
          wcnt  <= '0;
        end
        ST_ADDR: state <= cond ? ST_STRB : ST_DONE;
        ST_STRB, ST_WAIT: begin
          if (finish) state <= ST_DONE;
          else begin
            state <= ST_WAIT;
            if (wcnt != '1) wcnt <= wcnt + 1'b1;
          end
        end
        ST_DONE: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
  import ebc_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WAIT_W = 4,
  parameter int SH_W   = $clog2(ADDR_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SH_W-1:0]   cfg_bank_shift,
  input  logic [SH_W-1:0]   cfg_page_shift,
  input  logic [WAIT_W-1:0] cfg_min_wait,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic [1:0]        req_width,
  input  logic [39:0]       req_wdata,
  input  logic              req_cond,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [39:0]       rsp_rdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [3:0]        mem_sel_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_wr_early_n,
  output logic              mem_page_cross,
  output logic [47:0]       mem_dout,
  output logic              mem_doe,
  input  logic [47:0]       mem_din,
  input  logic              mem_ack
);
  seq_state_t         state;
  logic               finish, start;
  logic [NBANK-1:0]   sel_d, sel_q;
  logic [ADDR_W-1:0]  page_d, last_page;
  logic               last_valid, page_q;
  logic [ADDR_W-1:0]  addr_q;
  logic               wr_q, cond_q;
  op_width_t          width_q;
  logic [CORE_W-1:0]  wdata_q, rd_unpacked, rdata_q;
  logic [BUS_W-1:0]   wr_packed;
  logic               on_bus, strobing;

  assign req_ready = (state == ST_IDLE);
  assign start     = req_valid && req_ready;

  ebc_bank_decode #(.ADDR_W(ADDR_W), .NBANK(NBANK), .SH_W(SH_W)) u_dec (
    .addr       (req_addr),
    .bank_shift (cfg_bank_shift),
    .page_shift (cfg_page_shift),
    .sel_oh     (sel_d),
    .page_no    (page_d)
  );

  ebc_lane_mux u_lanes (
    .width      (width_q),
    .core_wdata (wdata_q),
    .bus_wdata  (wr_packed),
    .bus_rdata  (mem_din),
    .core_rdata (rd_unpacked)
  );

  ebc_seq #(.WAIT_W(WAIT_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cond      (cond_q),
    .min_wait  (cfg_min_wait),
    .ack       (mem_ack),
    .rsp_ready (rsp_ready),
    .state     (state),
    .finish    (finish)
  );

  // Request capture and bank 0 page tracking
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q     <= '0;
      wr_q       <= 1'b0;
      cond_q     <= 1'b0;
      width_q    <= OP_W32;
      wdata_q    <= '0;
      sel_q      <= '0;
      page_q     <= 1'b0;
      last_page  <= '0;
      last_valid <= 1'b0;
      rdata_q    <= '0;
    end else begin
      if (start) begin
        addr_q  <= req_addr;
        wr_q    <= req_write;
        cond_q  <= req_cond;
        width_q <= op_width_t'(req_width);
        wdata_q <= req_wdata;
        sel_q   <= sel_d;
        rdata_q <= '0;
        if (sel_d[0]) begin
          page_q     <= !last_valid || (page_d != last_page);
          last_page  <= page_d;
          last_valid <= 1'b1;
        end else begin
          page_q <= 1'b0;
        end
      end
      if (finish && !wr_q) rdata_q <= rd_unpacked;
    end
  end

  assign on_bus   = (state == ST_ADDR) || (state == ST_STRB) || (state == ST_WAIT);
  assign strobing = ((state == ST_STRB) || (state == ST_WAIT)) && cond_q;

  assign mem_addr       = addr_q;
  assign mem_sel_n      = on_bus ? ~sel_q : '1;
  assign mem_wr_early_n = !(on_bus && wr_q);
  assign mem_rd_n       = !(strobing && !wr_q);
  assign mem_wr_n       = !(strobing && wr_q);
  assign mem_page_cross = on_bus && page_q;
  assign mem_doe        = strobing && wr_q;
  assign mem_dout       = mem_doe ? wr_packed : '0;

  assign rsp_valid = (state == ST_DONE);
  assign rsp_rdata = rdata_q;
endmodule

// File: rtl/ebc_checker.sv
module ebc_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [39:0]       rsp_rdata,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_sel_n,
  input logic              mem_rd_n,
  input logic              mem_wr_n,
  input logic              mem_wr_early_n,
  input logic              mem_page_cross,
  input logic              mem_ack
);
  logic strobe_on;
  assign strobe_on = !mem_rd_n || !mem_wr_n;

  a_r1_one_bank: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_sel_n));

  a_r2_idle_no_select: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready || rsp_valid) |-> (mem_sel_n == 4'hF));

  a_r5_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_rd_n && !mem_wr_n));

  a_r4_write_warned: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_wr_n |-> !mem_wr_early_n);

  a_r6_ack_holds_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_on && !mem_ack) |=> strobe_on);

  a_r1_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |=> (strobe_on -> $stable(mem_addr)));

  a_r7_page_bank0: assert property (@(posedge clk) disable iff (!rst_n)
    mem_page_cross |-> !mem_sel_n[0]);

  a_r10_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_rdata)));
endmodule

bind ext_bus_ctrl ebc_checker #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/sim_ext_bus_ctrl.sv
module sim_ext_bus_ctrl;
  localparam int AW = 12;
  localparam int WW = 2;
  localparam int SW = $clog2(AW);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SW-1:0] cfg_bank_shift = SW'(8);
  logic [SW-1:0] cfg_page_shift = SW'(4);
  logic [WW-1:0] cfg_min_wait = '0;
  logic req_valid = 1'b0, req_ready, req_write = 1'b0, req_cond = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_width = '0;
  logic [39:0] req_wdata = '0;
  logic rsp_valid, rsp_ready = 1'b1;
  logic [39:0] rsp_rdata;
  logic [AW-1:0] mem_addr;
  logic [3:0] mem_sel_n;
  logic mem_rd_n, mem_wr_n, mem_wr_early_n, mem_page_cross, mem_doe;
  logic [47:0] mem_dout, mem_din = '0;
  logic mem_ack = 1'b1;

  int checks = 0, fails = 0;
  bit model_valid = 1'b0;
  logic [AW-1:0] model_page = '0;

  always #5 clk = ~clk;

  ext_bus_ctrl #(.ADDR_W(AW), .WAIT_W(WW)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] pack(input logic [1:0] w, input logic [39:0] d);
    case (w)
      2'd0: pack = {d[31:0], 16'h0};
      2'd1: pack = {d[39:0], 8'h0};
      2'd2: pack = {16'h0, d[15:0], 16'h0};
      default: pack = {24'h0, d[7:0], 16'h0};
    endcase
  endfunction

  function automatic logic [39:0] unpack(input logic [1:0] w, input logic [47:0] b);
    case (w)
      2'd0: unpack = {8'h0, b[47:16]};
      2'd1: unpack = b[47:8];
      2'd2: unpack = {24'h0, b[31:16]};
      default: unpack = {32'h0, b[23:16]};
    endcase
  endfunction

  task automatic access(input logic [AW-1:0] a, input bit wr, input logic [1:0] w,
                        input bit c, input logic [39:0] wd, input int k, input int rdly);
    int hi = int'(a) >> 8;
    logic [3:0] esel = (hi < 4) ? ~(4'b0001 << hi) : 4'hF;
    bit ep = 1'b0;
    int mw = int'(cfg_min_wait);
    int n = 0;
    int expn;
    logic [47:0] din = {a, a ^ 12'h5A5, wd[23:0]};
    logic [39:0] erd;
    if (hi == 0) begin
      ep = !model_valid || ((a >> 4) != model_page);
      model_page = a >> 4;
      model_valid = 1'b1;
    end
    expn = c ? (((mw > k) ? mw : k) + 1) : 0;
    erd = (wr || !c) ? 40'h0 : unpack(w, din);

    @(negedge clk);
    chk(req_ready == 1'b1, "R10 ready when idle", 48'(req_ready), 48'h1);
    req_valid = 1'b1; req_addr = a; req_write = wr; req_width = w;
    req_cond = c; req_wdata = wd; mem_din = din;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(mem_sel_n == esel, "R1 select in address cycle", 48'(mem_sel_n), 48'(esel));
    chk(mem_addr == a, "R1 address", 48'(mem_addr), 48'(a));
    chk(mem_wr_early_n == !wr, "R4 early write", 48'(mem_wr_early_n), 48'(!wr));
    chk(mem_page_cross == ep, "R7 page change", 48'(mem_page_cross), 48'(ep));
    chk(mem_rd_n && mem_wr_n, "R3 no strobe in address cycle", 48'({mem_rd_n, mem_wr_n}), 48'h3);

    @(negedge clk);
    while (!rsp_valid && n < 40) begin
      chk(mem_rd_n == wr && mem_wr_n == !wr, "R5 strobe kind",
          48'({mem_rd_n, mem_wr_n}), 48'({wr, !wr}));
      chk(mem_sel_n == esel, "R1 select held", 48'(mem_sel_n), 48'(esel));
      if (wr) chk(mem_doe && mem_dout == pack(w, wd), "R8 write lanes",
                  mem_dout, pack(w, wd));
      mem_ack = (n >= k);
      n++;
      @(negedge clk);
    end
    mem_ack = 1'b1;
    if (k > mw) chk(n == expn, "R6 strobe stretched by ack", 48'(n), 48'(expn));
    else if (c) chk(n == expn, "R5 strobe length", 48'(n), 48'(expn));
    else chk(n == 0, "R3 false condition has no strobe", 48'(n), 48'h0);
    if (wr && !c) chk(mem_wr_early_n == 1'b1, "R4 abandoned write", 48'(mem_wr_early_n), 48'h1);
    chk(mem_sel_n == 4'hF, "R2 selects idle at completion", 48'(mem_sel_n), 48'hF);
    chk(rsp_rdata == erd, "R9 read data", 48'(rsp_rdata), 48'(erd));
    if (rdly > 0) begin
      rsp_ready = 1'b0;
      repeat (rdly) begin
        @(negedge clk);
        chk(rsp_valid && rsp_rdata == erd && !req_ready, "R10 response held",
            48'(rsp_rdata), 48'(erd));
      end
      rsp_ready = 1'b1;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready && !rsp_valid, "R10 reset state", 48'({req_ready, rsp_valid}), 48'h2);
    chk(mem_sel_n == 4'hF, "R2 reset selects", 48'(mem_sel_n), 48'hF);
    chk(mem_rd_n && mem_wr_n && mem_wr_early_n, "R5 reset strobes",
        48'({mem_rd_n, mem_wr_n, mem_wr_early_n}), 48'h7);

    // Page sequence: first bank 0 access flags a change, same page does not
    access(12'h010, 1'b0, 2'd0, 1'b1, 40'h0, 0, 0);
    access(12'h01F, 1'b1, 2'd1, 1'b1, 40'hA1B2C3D4E5, 0, 0);
    access(12'h020, 1'b0, 2'd2, 1'b1, 40'h0, 0, 0);
    access(12'h120, 1'b0, 2'd3, 1'b1, 40'h0, 0, 0);
    access(12'h025, 1'b1, 2'd3, 1'b0, 40'h55, 0, 0);
    access(12'h0F0, 1'b0, 2'd0, 1'b0, 40'h0, 1, 2);

    // Sweep: min wait x ack delay x width x direction x condition
    for (int mw = 0; mw < 3; mw++) begin
      @(negedge clk);
      cfg_min_wait = WW'(mw);
      for (int k = 0; k < 3; k++)
        for (int w = 0; w < 4; w++)
          for (int d = 0; d < 2; d++)
            for (int c = 0; c < 2; c++) begin
              int idx = ((mw * 3 + k) * 4 + w) * 4 + d * 2 + c;
              logic [AW-1:0] a = AW'((idx * 173 + 5) % 1280);
              logic [39:0] wd = {8'(idx), 32'(idx * 32'h9E3779B1)};
              access(a, d[0], w[1:0], c[0], wd, k, (idx % 7 == 0) ? 2 : 0);
            end
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule